// File: doc/BRIEF.md
# Split-Access Fail Event Counter

This block keeps a 32-bit binary tally of fail events. Every clock cycle stands for one base period. In each cycle a vector of four fail strobes arrives, and the block adds the number of strobes that are set, from zero to four. The tally stops at all ones and does not wrap. A burst-start pulse sets the tally back to zero so that each pattern burst is counted from a clean state.

A host reaches the tally through two 16-bit registers on a simple synchronous register bus. A shared holding register makes the 16-bit accesses act as 32-bit ones:
- Reading the low half copies the whole live tally into the holding register. A later read of the high half returns the upper bits of that copy. The host therefore gets a coherent pair while counting goes on.
- Writing the low half fills the low half of the holding register. Writing the high half then loads all 32 bits into the tally at once.

Top module: `split_event_counter`

## Requirements
- R1: After reset the tally, the holding register and `bus_rdata` are all zero.
- R2: In every cycle with no preload and no burst clear, the tally grows by the number of set bits in `fail_vec` (0 to 4), with carries across the 16-bit boundary.
- R3: A read with `bus_addr`=0 returns, on `bus_rdata` one cycle later, the low 16 bits of the tally as it stood in the access cycle, before that cycle's increment. The same access copies all 32 bits of that tally value into the holding register.
- R4: A read with `bus_addr`=1 returns bits 31:16 of the holding register one cycle later, whatever the tally has done since the last low read.
- R5: A write with `bus_addr`=0 changes only bits 15:0 of the holding register. The tally keeps counting and is not changed by it.
- R6: A write with `bus_addr`=1 loads the tally with {written data, holding register bits 15:0} at the next clock edge.
- R7: A high write in the same cycle as fail strobes or a burst clear loads exactly the written value. The strobes and the clear are ignored in that cycle.
- R8: The tally saturates at 0xFFFFFFFF and stays there while more fails arrive.
- R9: `burst_clr` clears the tally to zero at the next edge, even when fails arrive in the same cycle. It leaves the holding register unchanged.
- R10: `bus_rdata` changes only after a read access. Idle cycles and writes leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one cycle is one base period |
| rst | input | 1 | Synchronous active-high reset |
| burst_clr | input | 1 | Burst-start pulse that clears the tally |
| fail_vec | input | 4 | Fail strobes for this period |
| bus_sel | input | 1 | Register access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 1 | 0 = low half, 1 = high half |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |

## Verification
The assertions assume that the host keeps to the intended access order: the low half is read before the high half, and the low half is written before the high half. They also assume that `burst_clr` and `fail_vec` are driven in the same cycle domain as the bus. The bench follows that order in every 32-bit access. It drives preloads both with the strobes quiet and with strobes and a clear arriving together. The second case checks the priority, which this block defines even though the host is not expected to rely on it. The saturation property checks growth only when neither a preload nor a clear is active, and the stimulus reaches the top of the range only through a preload.

// File: rtl/evtc_pkg.sv
package evtc_pkg;
  localparam logic ADDR_LO = 1'b0;
  localparam logic ADDR_HI = 1'b1;
endpackage

// File: rtl/lane_popcount.sv
module lane_popcount #(
  parameter int LANES = 4,
  localparam int SUM_W = $clog2(LANES + 1)
) (
  input  logic [LANES-1:0] lanes,
  output logic [SUM_W-1:0] sum
);
  logic [SUM_W-1:0] part [LANES+1];

  assign part[0] = '0;
  for (genvar i = 0; i < LANES; i++) begin : g_acc
    assign part[i+1] = part[i] + SUM_W'(lanes[i]);
  end
  assign sum = part[LANES];
endmodule

// File: rtl/tally_core.sv
module tally_core #(
  parameter int CNT_W = 32,
  parameter int LANES = 4,
  localparam int SUM_W = $clog2(LANES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [SUM_W-1:0] inc,
  output logic [CNT_W-1:0] cnt
);
  logic [CNT_W:0]   ext;
  logic [CNT_W-1:0] nxt_sat;

  always_comb begin
    ext     = {1'b0, cnt} + (CNT_W+1)'(inc);
    nxt_sat = ext[CNT_W] ? '1 : ext[CNT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (load) cnt <= load_val;
    else if (clr)  cnt <= '0;
    else           cnt <= nxt_sat;
  end

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    (!load && !clr) |=> (cnt >= $past(cnt))); // R8
  AST_SAT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!load && !clr && (&cnt)) |=> (&cnt)); // R8
  AST_STEP_BOUND: assert property (@(posedge clk) disable iff (rst)
    (!load && !clr) |=> ((cnt - $past(cnt)) <= CNT_W'(LANES))); // R2
  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (rst)
    (clr && !load) |=> (cnt == '0)); // R9
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt == $past(load_val))); // R7
endmodule

// File: rtl/host_port.sv
module host_port
  import evtc_pkg::*;
#(
  parameter int CNT_W = 32,
  localparam int HALF_W = CNT_W / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic              wr,
  input  logic              addr,
  input  logic [HALF_W-1:0] wdata,
  input  logic [CNT_W-1:0]  live,
  output logic [HALF_W-1:0] rdata,
  output logic              load,
  output logic [CNT_W-1:0]  load_val
);
  logic [CNT_W-1:0] hold;
  logic rd_lo, rd_hi, wr_lo;

  assign rd_lo    = sel && !wr && (addr == ADDR_LO);
  assign rd_hi    = sel && !wr && (addr == ADDR_HI);
  assign wr_lo    = sel && wr && (addr == ADDR_LO);
  assign load     = sel && wr && (addr == ADDR_HI);
  assign load_val = {wdata, hold[HALF_W-1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      hold  <= '0;
      rdata <= '0;
    end else begin
      if (rd_lo) begin
        rdata <= live[HALF_W-1:0];
        hold  <= live;
      end else if (rd_hi) begin
        rdata <= hold[CNT_W-1:HALF_W];
      end else if (wr_lo) begin
        hold[HALF_W-1:0] <= wdata;
      end
    end
  end

  AST_HI_FROM_HOLD: assert property (@(posedge clk) disable iff (rst)
    rd_hi |=> (rdata == $past(hold[CNT_W-1:HALF_W]))); // R4
  AST_SNAP_MATCH: assert property (@(posedge clk) disable iff (rst)
    rd_lo |=> (hold[HALF_W-1:0] == rdata)); // R3
  AST_RDATA_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!sel || wr) |=> $stable(rdata)); // R10
  AST_WLO_KEEPS_HI: assert property (@(posedge clk) disable iff (rst)
    wr_lo |=> $stable(hold[CNT_W-1:HALF_W])); // R5
endmodule

// File: rtl/split_event_counter.sv
module split_event_counter #(
  parameter int CNT_W = 32,
  parameter int LANES = 4,
  localparam int HALF_W = CNT_W / 2,
  localparam int SUM_W = $clog2(LANES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              burst_clr,
  input  logic [LANES-1:0]  fail_vec,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic              bus_addr,
  input  logic [HALF_W-1:0] bus_wdata,
  output logic [HALF_W-1:0] bus_rdata
);
  logic [SUM_W-1:0] inc;
  logic [CNT_W-1:0] cnt;
  logic             load;
  logic [CNT_W-1:0] load_val;

  lane_popcount #(.LANES(LANES)) u_pop (
    .lanes(fail_vec),
    .sum  (inc)
  );

  tally_core #(.CNT_W(CNT_W), .LANES(LANES)) u_core (
    .clk     (clk),
    .rst     (rst),
    .clr     (burst_clr),
    .load    (load),
    .load_val(load_val),
    .inc     (inc),
    .cnt     (cnt)
  );

  host_port #(.CNT_W(CNT_W)) u_host (
    .clk     (clk),
    .rst     (rst),
    .sel     (bus_sel),
    .wr      (bus_wr),
    .addr    (bus_addr),
    .wdata   (bus_wdata),
    .live    (cnt),
    .rdata   (bus_rdata),
    .load    (load),
    .load_val(load_val)
  );

  AST_RESET_ZERO: assert property (@(posedge clk)
    rst |=> (cnt == '0 && bus_rdata == '0)); // R1
endmodule

// File: tb/split_event_counter_bench.sv
module split_event_counter_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        burst_clr = 1'b0;
  logic [3:0]  fail_vec = '0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_addr = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  split_event_counter u_split_event_counter (
    .clk(clk), .rst(rst), .burst_clr(burst_clr), .fail_vec(fail_vec),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  // {fail pattern, repeat count, expected running total}
  localparam logic [39:0] TABLE [6] = '{
    {4'b0001, 4'd3, 32'd3},
    {4'b1111, 4'd2, 32'd11},
    {4'b0000, 4'd5, 32'd11},
    {4'b1010, 4'd4, 32'd19},
    {4'b0111, 4'd1, 32'd22},
    {4'b1101, 4'd3, 32'd31}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic a, output logic [15:0] v);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    v = bus_rdata;
  endtask

  task automatic rd32(output logic [31:0] v);
    logic [15:0] lo, hi;
    rd(1'b0, lo);
    rd(1'b1, hi);
    v = {hi, lo};
  endtask

  task automatic wr(input logic a, input logic [15:0] d, input logic [3:0] fv, input logic clr);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    fail_vec = fv; burst_clr = clr;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; fail_vec = '0; burst_clr = 1'b0;
  endtask

  task automatic preload(input logic [31:0] v);
    wr(1'b0, v[15:0], 4'b0000, 1'b0);
    wr(1'b1, v[31:16], 4'b0000, 1'b0);
  endtask

  task automatic fails(input logic [3:0] fv, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      fail_vec = fv;
    end
    @(negedge clk);
    fail_vec = '0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] v;
    logic [15:0] h;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 rdata after reset", 32'(bus_rdata), 32'h0);
    rd32(v);
    chk("R1 tally after reset", v, 32'h0);
    rd(1'b1, h);
    chk("R1 hold after reset", 32'(h), 32'h0);

    // R2 table walk
    for (int k = 0; k < 6; k++) begin
      fails(TABLE[k][39:36], int'(TABLE[k][35:32]));
      rd32(v);
      chk("R2 table total", v, TABLE[k][31:0]);
    end

    // R3/R4 coherent snapshot across a low-half carry
    preload(32'h0001_FFFE);
    rd(1'b0, h);
    chk("R3 low read", 32'(h), 32'h0000_FFFE);
    fails(4'b1111, 1);
    rd(1'b1, h);
    chk("R4 high from snapshot", 32'(h), 32'h0000_0001);
    rd32(v);
    chk("R2 carry into high half", v, 32'h0002_0002);

    // R3 low read during counting returns pre-increment value
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 1'b0; fail_vec = 4'b1111;
    @(negedge clk);
    bus_sel = 1'b0; fail_vec = '0;
    chk("R3 read during counting", 32'(bus_rdata), 32'h0000_0002);
    rd32(v);
    chk("R3 counting continued", v, 32'h0002_0006);

    // R5 low write touches only the holding low half
    wr(1'b0, 16'hABCD, 4'b0011, 1'b0);
    chk("R10 rdata unchanged by write", 32'(bus_rdata), 32'h0000_0002);
    rd(1'b1, h);
    chk("R5 hold high kept", 32'(h), 32'h0000_0002);
    wr(1'b0, 16'h1357, 4'b0000, 1'b0);
    wr(1'b1, 16'h0005, 4'b0000, 1'b0);
    rd32(v);
    chk("R6 high write loads", v, 32'h0005_1357);

    // R5 tally not changed by low write
    preload(32'h0000_0010);
    wr(1'b0, 16'h7777, 4'b0000, 1'b0);
    rd32(v);
    chk("R5 tally unaffected", v, 32'h0000_0010);

    // R7 preload wins over strobes and clear
    wr(1'b0, 16'h4444, 4'b0000, 1'b0);
    wr(1'b1, 16'h0033, 4'b1111, 1'b1);
    rd32(v);
    chk("R7 load wins", v, 32'h0033_4444);

    // R8 saturation
    preload(32'hFFFF_FFFD);
    fails(4'b1111, 2);
    rd32(v);
    chk("R8 saturate", v, 32'hFFFF_FFFF);
    fails(4'b0001, 3);
    rd32(v);
    chk("R8 stays saturated", v, 32'hFFFF_FFFF);

    // R9 burst clear wins over strobes, keeps hold
    @(negedge clk);
    burst_clr = 1'b1; fail_vec = 4'b1111;
    @(negedge clk);
    burst_clr = 1'b0; fail_vec = '0;
    rd(1'b1, h);
    chk("R9 hold kept by clear", 32'(h), 32'h0000_FFFF);
    rd32(v);
    chk("R9 clear", v, 32'h0);

    // R10 idle cycles with fails leave rdata alone
    fails(4'b0110, 4);
    chk("R10 rdata idle", 32'(bus_rdata), 32'h0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule